// File: doc/BRIEF.md
# Write-Drain Overlapped Refresh Scheduler

This block keeps the traffic phase of one channel of a multi-rank DRAM controller and decides when each rank gets its refresh. The channel serves reads and writes in separate phases, so the data bus turns around as seldom as possible. Writes build up in a queue during a read phase. Once enough of them have built up, the channel switches over and drains them.

Each rank owes one refresh per refresh interval. While the channel is in a read phase, the scheduler holds those refreshes back. It issues them once the channel is draining writes, so the time a rank spends refreshing is hidden behind write traffic instead of delaying reads. The number of refreshes a rank may owe is bounded. When a rank reaches that bound, its refresh is forced out whatever the phase. After each refresh the rank is reported busy for the refresh recovery time. During that time the command scheduler must not send it reads or writes, while the other ranks stay usable.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `phase_write` is 0 (read phase), `refresh_pulse` is all zeros and `rank_busy` is all zeros.
- R2: In a read phase, a write-queue level at or above `HI_WM` makes `phase_write` read 1 from the next cycle on.
- R3: In a write phase, a write-queue level at or below `LO_WM` while the read queue is non-empty makes `phase_write` read 0 from the next cycle on. Above `LO_WM` the write phase continues.
- R4: In a read phase with an empty read queue, any non-empty write queue starts a write phase in the next cycle. A write phase entered this way, with the read queue still empty, lasts until the write queue is empty.
- R5: Each rank owes one more refresh every `TREFI` cycles, counted from the release of reset. In a read phase, an owed refresh is not issued until that rank owes `MAX_POSTPONE` refreshes.
- R6: In a write phase, every rank that owes a refresh and is not busy receives a refresh pulse. Each pulse clears one owed refresh.
- R7: After a refresh pulse to rank r, `rank_busy[r]` is 1 for exactly `TRFC` cycles, starting in the next cycle. Other ranks keep their busy state.
- R8: At most one bit of `refresh_pulse` is set in any cycle. Among eligible ranks the lowest index wins, so refreshes due together go out one cycle apart.
- R9: A rank owing `MAX_POSTPONE` refreshes is refreshed in any phase. Such forced ranks take precedence over ranks that are only waiting for the write phase.
- R10: No refresh pulse is given to a rank while its `rank_busy` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wq_level | input | QW | Number of entries in the write queue |
| rq_level | input | QW | Number of entries in the read queue |
| phase_write | output | 1 | 1 = write phase, 0 = read phase |
| refresh_pulse | output | NUM_RANKS | One-cycle refresh command, one bit per rank |
| rank_busy | output | NUM_RANKS | Rank is recovering from a refresh and must get no reads or writes |

## Verification
The assertions take the queue levels to be stable for the whole cycle. They also take `TREFI` to be well above `TRFC` plus the rank count, so that a rank can never fall due again while it is still recovering or waiting for its slot, and `LO_WM` to be below `HI_WM`. The stimulus drives both levels only on the falling clock edge and uses a parameter set that meets these bounds. Directed phases hold the read queue busy long enough to reach the forced-refresh limit, cross each watermark and empty both queues. A pseudo-random sweep then changes both levels every few cycles across their full range.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    // Per-rank refresh status handed from a rank tracker to the arbiter
    typedef struct packed {
        logic owed;     // at least one refresh outstanding
        logic urgent;   // postponement limit reached
        logic blocked;  // inside refresh recovery window
    } rank_stat_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rfsh_phase_ctl.sv
module rfsh_phase_ctl
    import rfsh_pkg::*;
#(
    parameter int unsigned QW    = 6,
    parameter int unsigned HI_WM = 24,
    parameter int unsigned LO_WM = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [QW-1:0] wq_level,
    input  logic [QW-1:0] rq_level,
    output phase_e        phase_o
);

    phase_e ph_q, ph_d;
    logic   wq_high, wq_low, wq_empty, rd_idle;

    assign wq_high  = wq_level >= QW'(HI_WM);
    assign wq_low   = wq_level <= QW'(LO_WM);
    assign wq_empty = wq_level == '0;
    assign rd_idle  = rq_level == '0;

    // R2 R3 R4: watermark hysteresis plus opportunistic drain when reads are idle
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_READ:  if (wq_high || (rd_idle && !wq_empty)) ph_d = PH_WRITE;
            PH_WRITE: if (wq_empty || (wq_low && !rd_idle))  ph_d = PH_READ;
            default:  ph_d = PH_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_READ;
        else     ph_q <= ph_d;
    end

    assign phase_o = ph_q;

endmodule

// File: rtl/rfsh_rank_track.sv
module rfsh_rank_track
    import rfsh_pkg::*;
#(
    parameter int unsigned TREFI        = 3900,
    parameter int unsigned TRFC         = 208,
    parameter int unsigned MAX_POSTPONE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       grant_i,
    output rank_stat_t stat_o
);

    localparam int unsigned IW = cnt_w(TREFI);
    localparam int unsigned RW = cnt_w(TRFC + 1);
    localparam int unsigned PW = cnt_w(MAX_POSTPONE + 1);

    logic [IW-1:0] ival_q;
    logic [RW-1:0] rfc_q;
    logic [PW-1:0] owe_q;
    logic          due;

    assign due = ival_q == IW'(TREFI - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ival_q <= '0;
            rfc_q  <= '0;
            owe_q  <= '0;
        end else begin
            // R5: interval timer, one new obligation per wrap
            ival_q <= due ? '0 : ival_q + 1'b1;
            // R7: recovery window loaded by the grant
            if (grant_i)            rfc_q <= RW'(TRFC);
            else if (rfc_q != '0)   rfc_q <= rfc_q - 1'b1;
            case ({due, grant_i})
                2'b10: if (owe_q != PW'(MAX_POSTPONE)) owe_q <= owe_q + 1'b1;
                2'b01: owe_q <= owe_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign stat_o.owed    = owe_q != '0;
    assign stat_o.urgent  = owe_q == PW'(MAX_POSTPONE);
    assign stat_o.blocked = rfc_q != '0;

endmodule

// File: rtl/rfsh_grant_arb.sv
module rfsh_grant_arb
    import rfsh_pkg::*;
#(
    parameter int unsigned NR = 4
) (
    input  rank_stat_t [NR-1:0] stat_i,
    input  phase_e              phase_i,
    output logic [NR-1:0]       grant_o,
    output logic [NR-1:0]       urgent_o
);

    logic [NR-1:0] urg, opt, pick;

    always_comb begin
        for (int r = 0; r < NR; r++) begin
            // R9 R10: forced candidates, never while recovering
            urg[r] = stat_i[r].urgent && !stat_i[r].blocked;
            // R5 R6: opportunistic candidates only while draining writes
            opt[r] = stat_i[r].owed && !stat_i[r].blocked && (phase_i == PH_WRITE);
        end
        pick = (|urg) ? urg : opt;
    end

    // R8: isolate the lowest set bit, one refresh per cycle
    assign grant_o  = pick & (~pick + 1'b1);
    assign urgent_o = urg;

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned NUM_RANKS    = 4,
    parameter int unsigned QW           = 6,
    parameter int unsigned TREFI        = 3900,
    parameter int unsigned TRFC         = 208,
    parameter int unsigned HI_WM        = 24,
    parameter int unsigned LO_WM        = 8,
    parameter int unsigned MAX_POSTPONE = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [QW-1:0]        wq_level,
    input  logic [QW-1:0]        rq_level,
    output logic                 phase_write,
    output logic [NUM_RANKS-1:0] refresh_pulse,
    output logic [NUM_RANKS-1:0] rank_busy
);

    phase_e                     phase;
    rank_stat_t [NUM_RANKS-1:0] stat;
    logic [NUM_RANKS-1:0]       grant;
    logic [NUM_RANKS-1:0]       urg_vec;

    rfsh_phase_ctl #(
        .QW    (QW),
        .HI_WM (HI_WM),
        .LO_WM (LO_WM)
    ) i_phase (
        .clk      (clk),
        .rst      (rst),
        .wq_level (wq_level),
        .rq_level (rq_level),
        .phase_o  (phase)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        rfsh_rank_track #(
            .TREFI        (TREFI),
            .TRFC         (TRFC),
            .MAX_POSTPONE (MAX_POSTPONE)
        ) i_track (
            .clk     (clk),
            .rst     (rst),
            .grant_i (grant[r]),
            .stat_o  (stat[r])
        );
        assign rank_busy[r] = stat[r].blocked;
    end

    rfsh_grant_arb #(
        .NR (NUM_RANKS)
    ) i_arb (
        .stat_i   (stat),
        .phase_i  (phase),
        .grant_o  (grant),
        .urgent_o (urg_vec)
    );

    assign phase_write   = (phase == PH_WRITE);
    assign refresh_pulse = grant;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int unsigned NR    = 4,
    parameter int unsigned QW    = 6,
    parameter int unsigned HI_WM = 24,
    parameter int unsigned LO_WM = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [QW-1:0] wq_level,
    input logic [QW-1:0] rq_level,
    input logic          phase_write,
    input logic [NR-1:0] refresh_pulse,
    input logic [NR-1:0] rank_busy,
    input logic [NR-1:0] urgent_vec
);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0(refresh_pulse));

    a_r10_not_busy: assert property (@(posedge clk) disable iff (rst)
        (refresh_pulse & rank_busy) == '0);

    a_r5_read_only_forced: assert property (@(posedge clk) disable iff (rst)
        (!phase_write && (|refresh_pulse)) |-> (|(refresh_pulse & urgent_vec)));

    a_r2_enter_write: assert property (@(posedge clk) disable iff (rst)
        (!phase_write && wq_level >= QW'(HI_WM)) |=> phase_write);

    a_r3_leave_write: assert property (@(posedge clk) disable iff (rst)
        (phase_write && wq_level <= QW'(LO_WM) && rq_level != '0) |=> !phase_write);

    for (genvar r = 0; r < NR; r++) begin : g_busy
        a_r7_busy_follows: assert property (@(posedge clk) disable iff (rst)
            refresh_pulse[r] |=> rank_busy[r]);
    end

endmodule

bind rfsh_sched rfsh_sched_chk #(
    .NR    (NUM_RANKS),
    .QW    (QW),
    .HI_WM (HI_WM),
    .LO_WM (LO_WM)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .wq_level      (wq_level),
    .rq_level      (rq_level),
    .phase_write   (phase_write),
    .refresh_pulse (refresh_pulse),
    .rank_busy     (rank_busy),
    .urgent_vec    (urg_vec)
);

// File: tb/test_rfsh_sched.sv
`timescale 1ns/1ps
module test_rfsh_sched;

    localparam int NR    = 2;
    localparam int QW    = 5;
    localparam int TREFI = 40;
    localparam int TRFC  = 5;
    localparam int HI    = 12;
    localparam int LO    = 4;
    localparam int MAXP  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [QW-1:0] wq_level = '0;
    logic [QW-1:0] rq_level = '0;
    logic          phase_write;
    logic [NR-1:0] refresh_pulse;
    logic [NR-1:0] rank_busy;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rfsh_sched #(
        .NUM_RANKS    (NR),
        .QW           (QW),
        .TREFI        (TREFI),
        .TRFC         (TRFC),
        .HI_WM        (HI),
        .LO_WM        (LO),
        .MAX_POSTPONE (MAXP)
    ) i_rfsh_sched (
        .clk           (clk),
        .rst           (rst),
        .wq_level      (wq_level),
        .rq_level      (rq_level),
        .phase_write   (phase_write),
        .refresh_pulse (refresh_pulse),
        .rank_busy     (rank_busy)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model (driver side of the scoreboard) ----------
    typedef struct {
        bit            wr;
        logic [NR-1:0] pulse;
        logic [NR-1:0] busy;
    } exp_t;

    exp_t q[$];
    int   m_cnt;
    int   m_owe [NR];
    int   m_rfc [NR];
    bit   m_wr;

    function automatic logic [NR-1:0] model_pick();
        logic [NR-1:0] res = '0;
        for (int r = 0; r < NR; r++)          // R9: forced ranks first
            if (res == '0 && m_owe[r] == MAXP && m_rfc[r] == 0) res[r] = 1'b1;
        if (res == '0 && m_wr)                // R6: drain phase
            for (int r = 0; r < NR; r++)
                if (res == '0 && m_owe[r] > 0 && m_rfc[r] == 0) res[r] = 1'b1;
        return res;
    endfunction

    task automatic push_expect();
        exp_t e;
        e.wr    = m_wr;
        e.pulse = model_pick();
        for (int r = 0; r < NR; r++) e.busy[r] = (m_rfc[r] != 0);
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_wr = 0;
            for (int r = 0; r < NR; r++) begin m_owe[r] = 0; m_rfc[r] = 0; end
        end else begin
            logic [NR-1:0] g;
            bit due;
            g   = model_pick();
            due = (m_cnt == TREFI - 1);
            if (!m_wr) begin
                if (wq_level >= HI || (rq_level == 0 && wq_level != 0)) m_wr = 1;
            end else begin
                if (wq_level == 0 || (wq_level <= LO && rq_level != 0)) m_wr = 0;
            end
            m_cnt = due ? 0 : m_cnt + 1;
            for (int r = 0; r < NR; r++) begin
                if (g[r])             m_rfc[r] = TRFC;
                else if (m_rfc[r] > 0) m_rfc[r] = m_rfc[r] - 1;
                if (due && !g[r] && m_owe[r] < MAXP) m_owe[r] = m_owe[r] + 1;
                else if (g[r] && !due)               m_owe[r] = m_owe[r] - 1;
            end
        end
        push_expect();
    end

    // ---------------- monitor ---------------------------------------------------
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R2 R3 R4 phase", int'(phase_write), int'(e.wr));
            check("R6 R8 R9 R10 pulse", int'(refresh_pulse), int'(e.pulse));
            check("R7 busy", int'(rank_busy), int'(e.busy));
        end
    end

    // ---------------- directed stimulus ----------------------------------------
    initial begin
        int cnt;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state while reset asserted
        check("R1 phase", int'(phase_write), 0);
        check("R1 pulse", int'(refresh_pulse), 0);
        check("R1 busy", int'(rank_busy), 0);
        rq_level = 5'd5;
        rst = 1'b0;

        // R5: long read phase, two obligations per rank accrue, none issued
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (refresh_pulse != '0) cnt++;
        end
        check("R5 no refresh in read phase", cnt, 0);

        // R2: reach high watermark
        wq_level = 5'd12;
        @(negedge clk);
        check("R2 enter write", int'(phase_write), 1);
        // R6 R8: four staggered refreshes drained in the write phase
        cnt = (refresh_pulse != '0) ? 1 : 0;
        check("R8 rank0 first", int'(refresh_pulse), 1);
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (refresh_pulse != '0) cnt++;
        end
        check("R6 drained refreshes", cnt, 4);

        // R3: low watermark with reads waiting
        wq_level = 5'd6;
        @(negedge clk);
        check("R3 stay above low mark", int'(phase_write), 1);
        wq_level = 5'd4;
        @(negedge clk);
        check("R3 leave write", int'(phase_write), 0);

        // R9: postponement limit forces refreshes in read phase
        cnt = 0;
        for (int i = 0; i < 90; i++) begin
            @(negedge clk);
            if (refresh_pulse != '0) cnt++;
        end
        check("R9 forced refreshes", cnt, 2);

        // R4: idle-read drain
        rq_level = '0;
        wq_level = 5'd3;
        @(negedge clk);
        check("R4 idle drain enter", int'(phase_write), 1);
        repeat (5) @(negedge clk);
        check("R4 drain holds", int'(phase_write), 1);
        wq_level = '0;
        @(negedge clk);
        check("R4 drain ends empty", int'(phase_write), 0);

        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wq_level = lfsr[4:0];
            rq_level = (lfsr[7:5] == 3'd0) ? '0 : lfsr[12:8];
            repeat (7) @(negedge clk);
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule